// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time

This block is one pulse-width-modulation channel that drives a complementary pair of outputs, a high-side signal and a low-side signal, for a power stage. A 16-bit counter advances on a tick. The tick is either every clock cycle or the clock divided by a power-of-two prescaler and then by a linear divider. The counter runs either as a sawtooth (up only, left-aligned) or as a triangle (up then down, center-aligned). A raw PWM level is formed by comparing the counter against a duty value. That level is then shaped by a dead-time generator with separate delays for the high-side and low-side edges, an optional push-pull stage that sends the active phase to the two outputs on alternate periods, and two layers of inversion.

Period, duty and the dead-time word are written through a simple write port into shadow registers. An update request arms a transfer, and the shadow set is copied into the active set only at the next period boundary. A running waveform therefore never sees a half-applied setting. The mode, enable and inversion controls are static configuration inputs that act directly.

Top module: `pwm_comp_channel`

## Requirements
- R1: While `rst_n` is low (sampled on the clock edge), `cnt_val` is 0 and each output sits at its inactive level, which is `dt_inv_x ^ pol_x` for that output. Leaving reset, the active period, duty and dead-time word equal the parameters `RST_PERIOD`, `RST_DUTY` and `RST_DT`.
- R2: With `center_mode` = 0, the counter counts 0, 1, …, P and then returns to 0, so a period lasts P+1 ticks. `cnt_down` stays 0.
- R3: With `center_mode` = 1, the counter climbs from 0 to P and then falls back to 0, so a period lasts 2P ticks. `cnt_down` is 1 while the values P-1 down to 0 are shown, and the value P appears once per period.
- R4: The raw level is high while the counter is below the duty D. D = 0 keeps it low at all times, and D ≥ P keeps it high at all times. With dead-time off, the high output follows the raw level and the low output follows its complement, one clock after the counter.
- R5: The dead-time word holds the high-side delay in bits [15:8] and the low-side delay in bits [7:0], both counted in ticks. When `dt_en` = 1, the high output rises that many ticks after the raw level rises, and the low output rises that many ticks after it falls. When `dt_en` = 0, no delay is applied.
- R6: Before inversion, the high and low signals are never active in the same cycle.
- R7: With `push_pull` = 1, the raw active phase drives the high output in one period and the low output in the next. Otherwise both are inactive.
- R8: `dt_inv_hi` and `dt_inv_lo` each invert their dead-time-processed output.
- R9: `pol_hi` and `pol_lo` each invert their final output. Each combines by XOR with the matching R8 bit, so setting both for one output cancels.
- R10: A write (`wr_sel` 0 = period, 1 = duty, 2 = dead-time word) changes only the shadow value and has no effect on the outputs until `upd_req` is pulsed. After the pulse, the whole shadow set takes effect at the end of the period in progress.
- R11: With `clk_sel` = 0, the counter ticks every clock. With `clk_sel` = 1, it ticks every 2^k · max(`lin_div`,1) clocks, where `pre_sel` 0..7 selects 2^k = 1, 2, 4, 8, 16, 64, 256, 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 1 | 0: tick every clock, 1: prescaled tick |
| pre_sel | input | 3 | Power-of-two prescaler select |
| lin_div | input | LDIV_W | Linear divider, 0 treated as 1 |
| center_mode | input | 1 | 0: up counting, 1: up-down counting |
| push_pull | input | 1 | Alternate-period output steering |
| dt_en | input | 1 | Dead-time insertion enable |
| dt_inv_hi | input | 1 | Invert dead-time-processed high output |
| dt_inv_lo | input | 1 | Invert dead-time-processed low output |
| pol_hi | input | 1 | High output polarity |
| pol_lo | input | 1 | Low output polarity |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Shadow register select |
| wr_data | input | CNT_W | Write data |
| upd_req | input | 1 | Arm transfer of the shadow set at the next boundary |
| out_hi | output | 1 | High-side output |
| out_lo | output | 1 | Low-side output |
| cnt_val | output | CNT_W | Current counter value |
| cnt_down | output | 1 | Counter is in its falling half |

## Verification
The outputs are checked by counting, over whole periods, the cycles in which each output is high. Sawtooth, triangle, zero duty, duty equal to and above the period, and several dead-time and inversion settings each give a distinct pair of counts. A mistake in compare direction, delay length or inversion therefore shows up as a count error. The update buffer is probed at a point in the period where the old and new duty give different output levels, both before and after the boundary. Tick spacing is measured directly from the gaps between counter changes for several prescaler and divider settings.

// File: rtl/pwm_comp_pkg.sv
package pwm_comp_pkg;

   typedef enum logic [1:0] {
      SEL_PERIOD   = 2'd0,
      SEL_DUTY     = 2'd1,
      SEL_DEADTIME = 2'd2
   } wsel_e;

   // log2 of the power-of-two prescaler: 1,2,4,8,16,64,256,1024
   function automatic logic [3:0] pre_shift(input logic [2:0] sel);
      if (sel < 3'd5) return {1'b0, sel};
      else            return {sel, 1'b0} - 4'd4;
   endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
   import pwm_comp_pkg::*;
#(
   parameter int LDIV_W        = 8,
   parameter bit USE_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_sel,
   input  logic [2:0]        pre_sel,
   input  logic [LDIV_W-1:0] lin_div,
   output logic              tick
);

   localparam int TOT_W = 11 + LDIV_W;

   generate
      if (USE_PRESCALER) begin : g_pre
         logic [TOT_W-1:0] div_cnt;
         logic [TOT_W-1:0] pdiv;
         logic [TOT_W-1:0] ldiv;
         logic [TOT_W-1:0] total;
         logic             pre_tick;

         always_comb begin
            pdiv     = TOT_W'(1) << pre_shift(pre_sel);
            ldiv     = (lin_div == '0) ? TOT_W'(1) : TOT_W'(lin_div);
            total    = pdiv * ldiv;
            pre_tick = (div_cnt >= total - TOT_W'(1));
         end

         always_ff @(posedge clk) begin
            if (!rst_n)        div_cnt <= '0;
            else if (!clk_sel) div_cnt <= '0;
            else if (pre_tick) div_cnt <= '0;
            else               div_cnt <= div_cnt + TOT_W'(1);
         end

         assign tick = clk_sel ? pre_tick : 1'b1;

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_sel && tick && total > TOT_W'(1)) |=> (!tick || !clk_sel)); // R11
      end else begin : g_direct
         logic unused_cfg;
         assign unused_cfg = ^{clk_sel, pre_sel, lin_div};
         assign tick = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
   import pwm_comp_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DT_W  = 8,
   parameter logic [CNT_W-1:0] RST_PERIOD = 9,
   parameter logic [CNT_W-1:0] RST_DUTY   = 4,
   parameter logic [CNT_W-1:0] RST_DT     = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             upd_req,
   input  logic             boundary,
   output logic [CNT_W-1:0] act_per,
   output logic [CNT_W-1:0] act_duty,
   output logic [DT_W-1:0]  act_dth,
   output logic [DT_W-1:0]  act_dtl,
   output logic [CNT_W-1:0] sh_per,
   output logic             pend
);

   logic [CNT_W-1:0] sh_duty, sh_dt, act_dt;
   logic             copy;
   wsel_e            sel;

   assign sel  = wsel_e'(wr_sel);
   assign copy = boundary && pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_per  <= RST_PERIOD;
         sh_duty <= RST_DUTY;
         sh_dt   <= RST_DT;
      end else if (wr_en) begin
         case (sel)
            SEL_PERIOD:   sh_per  <= wr_data;
            SEL_DUTY:     sh_duty <= wr_data;
            SEL_DEADTIME: sh_dt   <= wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_per  <= RST_PERIOD;
         act_duty <= RST_DUTY;
         act_dt   <= RST_DT;
         pend     <= 1'b0;
      end else begin
         pend <= (pend && !boundary) || upd_req;
         if (copy) begin
            act_per  <= sh_per;
            act_duty <= sh_duty;
            act_dt   <= sh_dt;
         end
      end
   end

   assign act_dth = act_dt[2*DT_W-1:DT_W];
   assign act_dtl = act_dt[DT_W-1:0];

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !copy |=> ($stable(act_per) && $stable(act_duty) && $stable(act_dt))); // R10

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             center_mode,
   input  logic [CNT_W-1:0] act_per,
   input  logic [CNT_W-1:0] act_duty,
   input  logic [CNT_W-1:0] sh_per,
   input  logic             pend,
   output logic [CNT_W-1:0] cnt,
   output logic             down,
   output logic             boundary,
   output logic             phase,
   output logic             raw
);

   logic [CNT_W-1:0] nper;
   logic             at_top;

   assign at_top   = (cnt >= act_per);
   assign boundary = tick && (center_mode ? (down && cnt == '0) : at_top);
   assign nper     = (boundary && pend) ? sh_per : act_per;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         down  <= 1'b0;
         phase <= 1'b0;
      end else if (tick) begin
         if (boundary) phase <= ~phase;
         if (!center_mode) begin
            down <= 1'b0;
            cnt  <= at_top ? '0 : cnt + CNT_W'(1);
         end else if (down) begin
            if (cnt == '0) begin
               down <= 1'b0;
               cnt  <= (nper == '0) ? '0 : CNT_W'(1);
            end else begin
               cnt  <= cnt - CNT_W'(1);
            end
         end else if (at_top) begin
            down <= 1'b1;
            cnt  <= (act_per == '0) ? '0 : act_per - CNT_W'(1);
         end else begin
            cnt  <= cnt + CNT_W'(1);
         end
      end
   end

   always_comb begin
      if (act_duty == '0)           raw = 1'b0;
      else if (act_duty >= act_per) raw = 1'b1;
      else                          raw = (cnt < act_duty);
   end

   AST_LEFT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!center_mode && tick && cnt == act_per) |=> (cnt == '0)); // R2

   AST_CENTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (center_mode && tick && !down && cnt == act_per && act_per != '0)
      |=> (down && cnt == $past(act_per) - CNT_W'(1))); // R3

endmodule

// File: rtl/pwm_dt_stage.sv
module pwm_dt_stage #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            raw,
   input  logic            phase,
   input  logic            dt_en,
   input  logic            push_pull,
   input  logic [DT_W-1:0] dth,
   input  logic [DT_W-1:0] dtl,
   input  logic            dt_inv_hi,
   input  logic            dt_inv_lo,
   input  logic            pol_hi,
   input  logic            pol_lo,
   output logic            out_hi,
   output logic            out_lo
);

   logic            raw_prev, edge_seen, ready;
   logic [DT_W-1:0] dcnt, dnext;
   logic            hi_dt, lo_dt, hi_n, lo_n, hi_q, lo_q;

   assign edge_seen = raw ^ raw_prev;

   always_comb begin
      if (edge_seen)                 dnext = raw ? dth : dtl;
      else if (tick && dcnt != '0)   dnext = dcnt - DT_W'(1);
      else                           dnext = dcnt;
      ready = !dt_en || (dnext == '0);
      hi_dt = raw && ready;
      lo_dt = !raw && ready;
      hi_n  = push_pull ? (hi_dt && !phase) : hi_dt;
      lo_n  = push_pull ? (hi_dt && phase)  : lo_dt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_prev <= 1'b0;
         dcnt     <= '0;
         hi_q     <= 1'b0;
         lo_q     <= 1'b0;
      end else begin
         raw_prev <= raw;
         dcnt     <= dnext;
         hi_q     <= hi_n;
         lo_q     <= lo_n;
      end
   end

   assign out_hi = hi_q ^ dt_inv_hi ^ pol_hi;
   assign out_lo = lo_q ^ dt_inv_lo ^ pol_lo;

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q && lo_q)); // R6

   AST_HI_AFTER_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q |-> $past(raw)); // R5

endmodule

// File: rtl/pwm_comp_channel.sv
module pwm_comp_channel
   import pwm_comp_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter int DT_W          = 8,
   parameter int LDIV_W        = 8,
   parameter bit USE_PRESCALER = 1'b1,
   parameter logic [CNT_W-1:0] RST_PERIOD = 9,
   parameter logic [CNT_W-1:0] RST_DUTY   = 4,
   parameter logic [CNT_W-1:0] RST_DT     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_sel,
   input  logic [2:0]        pre_sel,
   input  logic [LDIV_W-1:0] lin_div,
   input  logic              center_mode,
   input  logic              push_pull,
   input  logic              dt_en,
   input  logic              dt_inv_hi,
   input  logic              dt_inv_lo,
   input  logic              pol_hi,
   input  logic              pol_lo,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              upd_req,
   output logic              out_hi,
   output logic              out_lo,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              cnt_down
);

   generate
      if (CNT_W != 2 * DT_W) begin : g_bad_dt
         $error("dead-time word must be two DT_W fields filling CNT_W");
      end
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W too small");
      end
      if (LDIV_W < 1) begin : g_bad_ldiv
         $error("LDIV_W must be at least 1");
      end
   endgenerate

   logic             tick, boundary, pend, phase, raw;
   logic [CNT_W-1:0] act_per, act_duty, sh_per;
   logic [DT_W-1:0]  act_dth, act_dtl;

   pwm_tick_gen #(.LDIV_W(LDIV_W), .USE_PRESCALER(USE_PRESCALER)) u_tick (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .pre_sel(pre_sel),
      .lin_div(lin_div), .tick(tick)
   );

   pwm_shadow_regs #(
      .CNT_W(CNT_W), .DT_W(DT_W),
      .RST_PERIOD(RST_PERIOD), .RST_DUTY(RST_DUTY), .RST_DT(RST_DT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .upd_req(upd_req), .boundary(boundary),
      .act_per(act_per), .act_duty(act_duty), .act_dth(act_dth),
      .act_dtl(act_dtl), .sh_per(sh_per), .pend(pend)
   );

   pwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .center_mode(center_mode),
      .act_per(act_per), .act_duty(act_duty), .sh_per(sh_per), .pend(pend),
      .cnt(cnt_val), .down(cnt_down), .boundary(boundary), .phase(phase),
      .raw(raw)
   );

   pwm_dt_stage #(.DT_W(DT_W)) u_dt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw), .phase(phase),
      .dt_en(dt_en), .push_pull(push_pull), .dth(act_dth), .dtl(act_dtl),
      .dt_inv_hi(dt_inv_hi), .dt_inv_lo(dt_inv_lo),
      .pol_hi(pol_hi), .pol_lo(pol_lo),
      .out_hi(out_hi), .out_lo(out_lo)
   );

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick && boundary) |-> (cnt_val <= act_per || cnt_val == 1)); // R2

endmodule

// File: tb/pwm_comp_channel_test.sv
module pwm_comp_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_sel = 1'b0;
   logic [2:0]  pre_sel = 3'd0;
   logic [7:0]  lin_div = 8'd1;
   logic        center_mode = 1'b0, push_pull = 1'b0, dt_en = 1'b0;
   logic        dt_inv_hi = 1'b0, dt_inv_lo = 1'b0, pol_hi = 1'b0, pol_lo = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = '0;
   logic        upd_req = 1'b0;
   logic        out_hi, out_lo, cnt_down;
   logic [15:0] cnt_val;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int cur_p = 9;
   int nh, nl, ntop, ndown, nboth;

   pwm_comp_channel uut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .pre_sel(pre_sel),
      .lin_div(lin_div), .center_mode(center_mode), .push_pull(push_pull),
      .dt_en(dt_en), .dt_inv_hi(dt_inv_hi), .dt_inv_lo(dt_inv_lo),
      .pol_hi(pol_hi), .pol_lo(pol_lo), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .upd_req(upd_req), .out_hi(out_hi), .out_lo(out_lo),
      .cnt_val(cnt_val), .cnt_down(cnt_down)
   );

   always #2.5 clk = ~clk;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] s, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic trigger();
      @(negedge clk); upd_req = 1'b1;
      @(negedge clk); upd_req = 1'b0;
   endtask

   task automatic load(int p, int d, int dtw);
      wr(2'd0, 16'(p)); wr(2'd1, 16'(d)); wr(2'd2, 16'(dtw));
      trigger();
      cur_p = p;
      cycles(4 * (p + 1) + 10);
   endtask

   task automatic sample(int n);
      nh = 0; nl = 0; ntop = 0; ndown = 0; nboth = 0;
      repeat (n) begin
         @(negedge clk);
         nh += int'(out_hi);
         nl += int'(out_lo);
         ndown += int'(cnt_down);
         if (int'(cnt_val) == cur_p) ntop++;
         if (out_hi && out_lo) nboth++;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pol_hi = 1'b1; dt_inv_lo = 1'b1;
      cycles(3);
      chk("R1 reset out_hi at pol level", int'(out_hi), 1);
      chk("R1 reset out_lo at dt_inv level", int'(out_lo), 1);
      chk("R1 reset counter", int'(cnt_val), 0);
      pol_hi = 1'b0; dt_inv_lo = 1'b0;
      cycles(1);
      chk("R1 reset out_hi inactive", int'(out_hi), 0);
      chk("R1 reset out_lo inactive", int'(out_lo), 0);
      rst_n = 1'b1;
      cycles(30);
      sample(40);
      chk("R1 reset-value duty hi count", nh, 16);
      chk("R1 reset-value duty lo count", nl, 24);
   endtask

   task automatic t_left();
      load(19, 7, 0);
      sample(60);
      chk("R2 R4 left hi count", nh, 21);
      chk("R4 left lo count", nl, 39);
      chk("R2 top value once per period", ntop, 3);
      chk("R2 no down phase", ndown, 0);
   endtask

   task automatic t_center();
      center_mode = 1'b1;
      cycles(100);
      sample(76);
      chk("R3 center hi count", nh, 26);
      chk("R3 center down cycles", ndown, 38);
      chk("R3 center top once per period", ntop, 2);
      center_mode = 1'b0;
      cycles(50);
   endtask

   task automatic t_duty_edges();
      load(9, 0, 0);
      sample(20);
      chk("R4 duty zero hi", nh, 0);
      chk("R4 duty zero lo", nl, 20);
      load(9, 9, 0);
      sample(20);
      chk("R4 duty equal period hi", nh, 20);
      load(9, 12, 0);
      sample(20);
      chk("R4 duty above period hi", nh, 20);
      chk("R4 duty above period lo", nl, 0);
   endtask

   task automatic t_deadtime();
      dt_en = 1'b0;
      load(9, 5, 16'h0203);
      sample(20);
      chk("R5 disabled hi", nh, 10);
      chk("R5 disabled lo", nl, 10);
      dt_en = 1'b1;
      cycles(20);
      sample(40);
      chk("R5 high-side delay", nh, 12);
      chk("R5 low-side delay", nl, 8);
      chk("R6 no overlap", nboth, 0);
   endtask

   task automatic t_pushpull();
      dt_en = 1'b0;
      load(9, 4, 0);
      push_pull = 1'b1;
      cycles(30);
      sample(40);
      chk("R7 push-pull hi", nh, 8);
      chk("R7 push-pull lo", nl, 8);
      chk("R6 R7 push-pull no overlap", nboth, 0);
      push_pull = 1'b0;
      cycles(30);
   endtask

   task automatic t_invert();
      pol_hi = 1'b1;
      cycles(5);
      sample(20);
      chk("R9 pol_hi inverts", nh, 12);
      chk("R9 pol_hi leaves lo", nl, 12);
      pol_hi = 1'b0;
      dt_en = 1'b1;
      load(9, 5, 16'h0203);
      dt_inv_lo = 1'b1;
      cycles(5);
      sample(20);
      chk("R8 dt_inv_lo inverts", nl, 16);
      chk("R8 dt_inv_lo leaves hi", nh, 6);
      pol_lo = 1'b1;
      cycles(2);
      sample(20);
      chk("R9 pol_lo cancels dt_inv_lo", nl, 4);
      dt_inv_hi = 1'b1;
      cycles(2);
      sample(20);
      chk("R8 dt_inv_hi inverts", nh, 14);
      dt_inv_hi = 1'b0; dt_inv_lo = 1'b0; pol_lo = 1'b0; dt_en = 1'b0;
   endtask

   task automatic t_buffer();
      int gap;
      load(9, 4, 0);
      wr(2'd1, 16'd7);
      wr(2'd0, 16'd14);
      cycles(40);
      sample(20);
      chk("R10 write without trigger ignored", nh, 8);
      while (cnt_val != 16'd2) @(negedge clk);
      upd_req = 1'b1;
      @(negedge clk);
      upd_req = 1'b0;
      while (cnt_val != 16'd6) @(negedge clk);
      chk("R10 old duty until boundary", int'(out_hi), 0);
      while (cnt_val != 16'd0) @(negedge clk);
      while (cnt_val != 16'd6) @(negedge clk);
      chk("R10 new duty after boundary", int'(out_hi), 1);
      while (cnt_val != 16'd0) @(negedge clk);
      gap = 0;
      do begin @(negedge clk); gap++; end while (cnt_val != 16'd0);
      chk("R10 new period after boundary", gap, 15);
      cur_p = 14;
   endtask

   task automatic tick_gap(output int gap);
      logic [15:0] prev;
      for (int i = 0; i < 3; i++) begin
         prev = cnt_val;
         gap = 0;
         do begin @(negedge clk); gap++; end while (cnt_val == prev);
      end
   endtask

   task automatic t_prescale();
      int g;
      clk_sel = 1'b0;
      tick_gap(g);
      chk("R11 direct tick", g, 1);
      clk_sel = 1'b1; pre_sel = 3'd2; lin_div = 8'd3;
      tick_gap(g);
      chk("R11 div 4 x 3", g, 12);
      pre_sel = 3'd5; lin_div = 8'd0;
      tick_gap(g);
      chk("R11 div 64 x (0 as 1)", g, 64);
      pre_sel = 3'd7; lin_div = 8'd1;
      tick_gap(g);
      chk("R11 div 1024", g, 1024);
      clk_sel = 1'b0;
      cycles(4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1-all actual=timeout expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_left();
      t_center();
      t_duty_edges();
      t_deadtime();
      t_pushpull();
      t_invert();
      t_buffer();
      t_prescale();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule